// File: doc/BRIEF.md
# Video Stream Start-of-Frame Checker

This block sits passively on a streaming video link between a pixel producer and a frame-buffer writer. Every signal passes straight through: data, sideband, line-end and valid go downstream, and the ready goes upstream, all without modification. The block never stalls the link. Bit 0 of the user sideband carries the start-of-frame marker. The block counts a beat only when valid and ready are both high. It issues a one-cycle frame-start strobe on the accepted beat that carries the marker.

From each marker the checker counts pixels per line and lines per frame, and compares them against two configuration inputs. A marker may be raised early, during cycles where valid is low. Such cycles are neither a frame start nor an error. The checker reports four conditions on sticky flags: a line of the wrong length, a frame cut short by a new marker, a completed frame followed by a beat without a marker, and a marker dropped before any valid beat carried it. A completed frame with no line fault produces a one-cycle good-frame pulse.

Top module: `vid_sof_monitor`

## Requirements
- R1: `m_tdata`, `m_tuser`, `m_tlast` and `m_tvalid` equal `s_tdata`, `s_tuser`, `s_tlast` and `s_tvalid` in the same cycle. `s_tready` equals `m_tready`.
- R2: A beat is accepted only in a cycle where `s_tvalid` and `m_tready` are both 1. Pixel and line counting advances only on accepted beats.
- R3: `sof_strobe` is 1 exactly in the cycle of an accepted beat with `s_tuser[0]`=1. Cycles where the marker is high and `s_tvalid` is 0 produce no strobe and no error.
- R4: On an accepted beat with `s_tlast`=1 in a counted line, if the number of pixels in that line (including this beat) differs from `cfg_line_px`, then `err_flags[0]` is set.
- R5: If `s_tuser[0]` is 1 with `s_tvalid` 0 in one cycle and `s_tuser[0]` is 0 in the next cycle, then `err_flags[3]` is set.
- R6: An accepted marker beat that arrives while a frame has fewer than `cfg_frame_ln` completed lines sets `err_flags[1]`. Counting restarts with that beat as pixel 1 of line 1.
- R7: After a frame completes, if the next accepted beat has no marker, `err_flags[2]` is set. Accepted beats are then ignored (no counting, no line errors, no good pulse) until a marker beat arrives.
- R8: `frame_good` pulses for one cycle, in the cycle after the accepted `s_tlast` beat that completes line `cfg_frame_ln` of a frame in which no line-length fault occurred.
- R9: Each bit of `err_flags` is set in the cycle after its event and stays set until `err_clr` is 1. `err_clr` clears all bits, except that an event in the same cycle as `err_clr` leaves its bit set.
- R10: When `rst_n` is 0 at a clock edge, the block returns to waiting for a marker, with `err_flags`=0 and `frame_good`=0. While waiting, beats without a marker are ignored and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_clr | input | 1 | Pulse to clear the sticky error flags |
| cfg_line_px | input | PXW | Pixels per line |
| cfg_frame_ln | input | LNW | Lines per frame |
| s_tdata | input | DW | Upstream pixel data |
| s_tuser | input | UW | Upstream sideband; bit 0 is the frame marker |
| s_tlast | input | 1 | Upstream end-of-line |
| s_tvalid | input | 1 | Upstream valid |
| s_tready | output | 1 | Ready returned upstream (copy of m_tready) |
| m_tdata | output | DW | Downstream pixel data |
| m_tuser | output | UW | Downstream sideband |
| m_tlast | output | 1 | Downstream end-of-line |
| m_tvalid | output | 1 | Downstream valid |
| m_tready | input | 1 | Downstream ready |
| sof_strobe | output | 1 | Frame-start strobe on the accepted marker beat |
| frame_good | output | 1 | One-cycle pulse after a well-formed frame |
| err_flags | output | 4 | Sticky flags: [0] line length, [1] early frame, [2] missing marker, [3] dropped marker |

## Verification
Two functions can fall in the same cycle: a clear pulse and a new error event. The bench provokes this by driving `err_clr` high on the same beat as the `s_tlast` of a short line, while an older dropped-marker flag is already set. The expected result is that the old flag clears and the line-length flag is set. The second collision is a new marker that lands on a beat before the programmed line count is reached. That beat must raise the early-frame flag and also begin a fresh frame, and that fresh frame is then expected to produce a good-frame pulse. A behavioural reference model judges every cycle, and directed checks at the end of each scenario confirm the result.

// File: rtl/vsm_pkg.sv
// Shared types for the start-of-frame checker.
// Assumes: error flag bit positions are fixed and visible at the top ports.
package vsm_pkg;
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,   // waiting for a marker beat
        ST_RUN  = 2'd1,   // counting a frame
        ST_DONE = 2'd2    // frame complete, next beat must carry a marker
    } vsm_state_t;

    localparam int ERR_W       = 4;
    localparam int ERR_LINE    = 0;
    localparam int ERR_EARLY   = 1;
    localparam int ERR_MISSING = 2;
    localparam int ERR_DROPPED = 3;
endpackage

// File: rtl/vsm_beat_qual.sv
// Qualifies the handshake and the frame marker.
// Produces an accepted-beat signal and a marker-beat signal. Also detects a
// marker that was raised while valid was low and then dropped before any valid beat.
// Assumes: the marker is bit 0 of the user sideband.
module vsm_beat_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic tvalid,
    input  logic tready,
    input  logic marker,
    output logic beat,
    output logic mark_beat,
    output logic dropped_ev
);
    logic early_pend;

    assign beat       = tvalid && tready;
    assign mark_beat  = beat && marker;
    assign dropped_ev = early_pend && !marker;

    // Remember that the marker was high in a cycle with valid low.
    always_ff @(posedge clk) begin
        if (!rst_n) early_pend <= 1'b0;
        else        early_pend <= marker && !tvalid;
    end
endmodule

// File: rtl/vsm_frame_trk.sv
// Tracks frame position: pixel count within a line, completed lines, and the
// frame state. Raises line-length, early-frame and missing-marker events, and
// produces a registered good-frame pulse.
// Assumes: cfg_frame_ln >= 1 and cfg_line_px >= 1, both stable while a frame runs.
module vsm_frame_trk
    import vsm_pkg::*;
#(
    parameter int PXW = 12,
    parameter int LNW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           beat,
    input  logic           mark_beat,
    input  logic           last,
    input  logic [PXW-1:0] cfg_px,
    input  logic [LNW-1:0] cfg_ln,
    output logic           ev_line,
    output logic           ev_early,
    output logic           ev_missing,
    output logic           good_pulse
);
    vsm_state_t     st_q, st_d;
    logic [PXW-1:0] px_q, px_d, px_base, px_inc;
    logic [LNW-1:0] ln_q, ln_d, ln_base, ln_inc;
    logic           bad_q, bad_d, bad_base;
    logic           count, good_d;

    // Next-state and event decode for one accepted beat.
    always_comb begin
        st_d = st_q; px_d = px_q; ln_d = ln_q; bad_d = bad_q;
        px_base = '0; ln_base = '0; bad_base = 1'b0;
        px_inc = '0; ln_inc = '0;
        count = 1'b0; good_d = 1'b0;
        ev_line = 1'b0; ev_early = 1'b0; ev_missing = 1'b0;
        if (beat) begin
            if (mark_beat) begin
                ev_early = (st_q == ST_RUN);
                st_d     = ST_RUN;
                count    = 1'b1;
            end else if (st_q == ST_RUN) begin
                px_base  = px_q;
                ln_base  = ln_q;
                bad_base = bad_q;
                count    = 1'b1;
            end else if (st_q == ST_DONE) begin
                ev_missing = 1'b1;
                st_d       = ST_WAIT;
            end
            if (count) begin
                px_inc = px_base + 1'b1;
                if (last) begin
                    ev_line = (px_inc != cfg_px);
                    bad_d   = bad_base || ev_line;
                    px_d    = '0;
                    ln_inc  = ln_base + 1'b1;
                    ln_d    = ln_inc;
                    if (ln_inc == cfg_ln) begin
                        st_d   = ST_DONE;
                        good_d = !(bad_base || ev_line);
                    end
                end else begin
                    px_d  = px_inc;
                    ln_d  = ln_base;
                    bad_d = bad_base;
                end
            end
        end
    end

    // Frame position registers and the good-frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_WAIT;
            px_q       <= '0;
            ln_q       <= '0;
            bad_q      <= 1'b0;
            good_pulse <= 1'b0;
        end else begin
            st_q       <= st_d;
            px_q       <= px_d;
            ln_q       <= ln_d;
            bad_q      <= bad_d;
            good_pulse <= good_d;
        end
    end
endmodule

// File: rtl/vsm_err_flags.sv
// Bank of sticky error flags.
// Each flag is set by its event and cleared by a clear pulse. An event in the
// same cycle as the clear wins.
// Assumes: events are single-cycle qualified pulses.
module vsm_err_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] ev,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky bit: set on its event, drop on clear.
        always_ff @(posedge clk) begin
            if (!rst_n)     flags[i] <= 1'b0;
            else if (ev[i]) flags[i] <= 1'b1;
            else if (clr)   flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/vid_sof_monitor.sv
// Passive start-of-frame and frame-size checker for a streaming video link.
// Passes the stream through unchanged and never applies backpressure.
// Checks each frame's geometry from its marker beat.
// Assumes: the marker is s_tuser[0], and s_tlast ends each line.
module vid_sof_monitor
    import vsm_pkg::*;
#(
    parameter int DW  = 24,
    parameter int UW  = 1,
    parameter int PXW = 12,
    parameter int LNW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_clr,
    input  logic [PXW-1:0]   cfg_line_px,
    input  logic [LNW-1:0]   cfg_frame_ln,
    input  logic [DW-1:0]    s_tdata,
    input  logic [UW-1:0]    s_tuser,
    input  logic             s_tlast,
    input  logic             s_tvalid,
    output logic             s_tready,
    output logic [DW-1:0]    m_tdata,
    output logic [UW-1:0]    m_tuser,
    output logic             m_tlast,
    output logic             m_tvalid,
    input  logic             m_tready,
    output logic             sof_strobe,
    output logic             frame_good,
    output logic [ERR_W-1:0] err_flags
);
    logic             beat, mark_beat, dropped_ev;
    logic             ev_line, ev_early, ev_missing;
    logic [ERR_W-1:0] ev_vec;

    // Straight pass-through of the link.
    assign m_tdata  = s_tdata;
    assign m_tuser  = s_tuser;
    assign m_tlast  = s_tlast;
    assign m_tvalid = s_tvalid;
    assign s_tready = m_tready;

    vsm_beat_qual u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .tvalid    (s_tvalid),
        .tready    (m_tready),
        .marker    (s_tuser[0]),
        .beat      (beat),
        .mark_beat (mark_beat),
        .dropped_ev(dropped_ev)
    );

    vsm_frame_trk #(.PXW(PXW), .LNW(LNW)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat      (beat),
        .mark_beat (mark_beat),
        .last      (s_tlast),
        .cfg_px    (cfg_line_px),
        .cfg_ln    (cfg_frame_ln),
        .ev_line   (ev_line),
        .ev_early  (ev_early),
        .ev_missing(ev_missing),
        .good_pulse(frame_good)
    );

    // Gather events into flag positions.
    always_comb begin
        ev_vec              = '0;
        ev_vec[ERR_LINE]    = ev_line;
        ev_vec[ERR_EARLY]   = ev_early;
        ev_vec[ERR_MISSING] = ev_missing;
        ev_vec[ERR_DROPPED] = dropped_ev;
    end

    vsm_err_flags #(.N(ERR_W)) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (err_clr),
        .ev   (ev_vec),
        .flags(err_flags)
    );

    assign sof_strobe = mark_beat;
endmodule

// File: rtl/vsm_sva.sv
// Property checker for vid_sof_monitor, attached by bind.
// Relates the flag and pulse outputs to the port activity in the cycle before.
module vsm_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       err_clr,
    input logic       s_tvalid,
    input logic       m_tready,
    input logic       marker,
    input logic       s_tlast,
    input logic       sof_strobe,
    input logic       frame_good,
    input logic [3:0] err_flags
);
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    p_good_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_good |-> $past(s_tvalid && m_tready && s_tlast));

    p_good_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_good |=> !frame_good);

    p_early_on_marker_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[1]) |-> $past(sof_strobe));

    p_missing_no_marker_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[2]) |-> $past(s_tvalid && m_tready && !marker));

    p_dropped_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[3]) |-> $past(!marker));

    p_line_on_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[0]) |-> $past(s_tvalid && m_tready && s_tlast));
endmodule

bind vid_sof_monitor vsm_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_clr   (err_clr),
    .s_tvalid  (s_tvalid),
    .m_tready  (m_tready),
    .marker    (s_tuser[0]),
    .s_tlast   (s_tlast),
    .sof_strobe(sof_strobe),
    .frame_good(frame_good),
    .err_flags (err_flags)
);

// File: tb/sim_vid_sof_monitor.sv
module sim_vid_sof_monitor;
    localparam int DW = 24, UW = 1, PXW = 12, LNW = 12;
    localparam int NPX = 4, NLN = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic err_clr = 1'b0;
    logic [PXW-1:0] cfg_line_px = PXW'(NPX);
    logic [LNW-1:0] cfg_frame_ln = LNW'(NLN);
    logic [DW-1:0] s_tdata = '0;
    logic [UW-1:0] s_tuser = '0;
    logic s_tlast = 1'b0, s_tvalid = 1'b0, m_tready = 1'b1;
    logic s_tready, m_tlast, m_tvalid, sof_strobe, frame_good;
    logic [DW-1:0] m_tdata;
    logic [UW-1:0] m_tuser;
    logic [3:0] err_flags;

    int total = 0, bad = 0;
    int sof_cnt = 0, good_cnt = 0;
    bit bp_en = 0;

    always #2 clk = ~clk;

    vid_sof_monitor #(.DW(DW), .UW(UW), .PXW(PXW), .LNW(LNW)) u0 (.*);

    // Behavioural reference model
    int  mst = 0;            // 0 wait, 1 run, 2 done
    int  mpx = 0, mln = 0;
    bit  mbad = 0, mpend = 0, mgood = 0;
    bit [3:0] mflags = '0;

    always @(posedge clk) begin
        bit [3:0] ev;
        bit acc, mk, cnt;
        if (!rst_n) begin
            mst = 0; mpx = 0; mln = 0; mbad = 0; mpend = 0; mgood = 0; mflags = '0;
        end else begin
            ev = '0; mgood = 0; cnt = 0;
            acc = s_tvalid && m_tready;
            mk = s_tuser[0];
            if (mpend && !mk) ev[3] = 1;
            mpend = mk && !s_tvalid;
            if (acc) begin
                if (mk) begin
                    if (mst == 1) ev[1] = 1;
                    mst = 1; mpx = 0; mln = 0; mbad = 0; cnt = 1;
                end else if (mst == 1) cnt = 1;
                else if (mst == 2) begin ev[2] = 1; mst = 0; end
                if (cnt) begin
                    mpx++;
                    if (s_tlast) begin
                        if (mpx != NPX) begin ev[0] = 1; mbad = 1; end
                        mpx = 0; mln++;
                        if (mln == NLN) begin mst = 2; mgood = !mbad; end
                    end
                end
            end
            mflags = err_clr ? ev : (mflags | ev);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance one clock and compare everything against the model.
    task automatic step();
        @(posedge clk);
        #1;
        chk("R1 pass-through", {m_tdata, m_tuser, m_tlast, m_tvalid, s_tready},
            {s_tdata, s_tuser, s_tlast, s_tvalid, m_tready});
        chk("R3 sof_strobe", sof_strobe, s_tvalid && m_tready && s_tuser[0]);
        chk("R4 line flag", err_flags[0], mflags[0]);
        chk("R6 early flag", err_flags[1], mflags[1]);
        chk("R7 missing flag", err_flags[2], mflags[2]);
        chk("R5 dropped flag", err_flags[3], mflags[3]);
        chk("R8 frame_good", frame_good, mgood);
        if (sof_strobe) sof_cnt++;
        if (frame_good) good_cnt++;
    endtask

    task automatic send(input bit mk, input bit last, input bit clr = 0);
        s_tvalid = 1; s_tuser[0] = mk; s_tlast = last; s_tdata = s_tdata + 1;
        if (bp_en) begin m_tready = 0; step(); end
        m_tready = 1; err_clr = clr;
        step();
        err_clr = 0;
    endtask

    task automatic idle(input int n);
        s_tvalid = 0; s_tuser = '0; s_tlast = 0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic line(input bit mk, input int npx);
        for (int p = 0; p < npx; p++) send(mk && p == 0, p == npx - 1);
    endtask

    task automatic frame(input bit mk, input int nln);
        for (int l = 0; l < nln; l++) line(mk && l == 0, NPX);
    endtask

    task automatic clear();
        s_tvalid = 0; s_tuser = '0; err_clr = 1; step(); err_clr = 0; step();
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int g0, s0;
        step(); step();
        chk("R10 reset flags", err_flags, 0);
        chk("R10 reset good", frame_good, 0);
        rst_n = 1;
        idle(2);

        // R3: marker raised early with valid low, then a clean frame
        s_tuser[0] = 1; s_tvalid = 0;
        step(); step(); step();
        chk("R3 no strobe while valid low", sof_cnt, 0);
        chk("R3 no flag for early marker", err_flags, 0);
        g0 = good_cnt;
        frame(1, NLN);
        idle(2);
        chk("R3 one strobe per frame", sof_cnt, 1);
        chk("R8 good frame pulse", good_cnt - g0, 1);

        // R2: backpressure between beats
        bp_en = 1; g0 = good_cnt;
        frame(1, NLN);
        bp_en = 0;
        idle(2);
        chk("R2 stalled frame still good", good_cnt - g0, 1);
        chk("R2 no flags", err_flags, 0);

        // R4: short line
        g0 = good_cnt;
        line(1, NPX); line(0, NPX - 1); line(0, NPX);
        idle(2);
        chk("R4 short line flag", err_flags, 4'b0001);
        chk("R8 no good on bad frame", good_cnt - g0, 0);
        clear();
        chk("R9 cleared", err_flags, 0);

        // R4: long line
        line(1, NPX + 1); line(0, NPX); line(0, NPX);
        idle(2);
        chk("R4 long line flag", err_flags, 4'b0001);
        clear();

        // R6: early marker restarts counting
        g0 = good_cnt;
        frame(1, NLN - 1);
        frame(1, NLN);
        idle(2);
        chk("R6 early flag only", err_flags, 4'b0010);
        chk("R6 restarted frame good", good_cnt - g0, 1);
        clear();

        // R7: missing marker then ignored beats
        frame(1, NLN);
        g0 = good_cnt;
        frame(0, NLN);
        line(0, NPX - 2);
        idle(2);
        chk("R7 missing flag only", err_flags, 4'b0100);
        chk("R7 ignored beats give no good", good_cnt - g0, 0);
        frame(1, NLN);
        idle(1);
        chk("R7 recovery good", good_cnt - g0, 1);
        clear();

        // R5: dropped marker
        s_tvalid = 0; s_tuser[0] = 1; step();
        s_tuser[0] = 0; step(); step();
        chk("R5 dropped flag", err_flags, 4'b1000);

        // R9: clear and line error in the same cycle
        s0 = sof_cnt;
        line(1, NPX);
        for (int p = 0; p < NPX - 2; p++) send(0, 0);
        send(0, 1, 1);
        idle(1);
        chk("R9 event wins over clear", err_flags, 4'b0001);
        chk("R3 strobe counted", sof_cnt - s0, 1);
        frame(0, 0);
        line(0, NPX); line(0, NPX);
        idle(1);
        clear();

        // R10: reset mid-frame, then unmarked beats ignored
        frame(1, 1);
        line(0, 2);
        rst_n = 0; s_tvalid = 0; step(); rst_n = 1;
        g0 = good_cnt;
        frame(0, NLN);
        idle(2);
        chk("R10 waiting after reset", err_flags, 0);
        chk("R10 no good while waiting", good_cnt - g0, 0);

        finish_run();
    end
endmodule